// File: doc/BRIEF.md
# Framebuffer Control and Frame-End Interrupt Register File

This block is the upper sixteen bytes of a display controller's byte-wide register window. It sits at offsets 0x10 to 0x1F of a 32-byte window and serves three purposes. It holds an interrupt-enable control byte. It keeps a sticky pending-interrupt flag, which the display side sets with a one-cycle frame-end strobe. It also gives plain storage for cursor and video-control bytes. The lower half of the window belongs to other logic, so this block reads zero there and ignores writes there.

Writes take effect at the rising clock edge. Reads are combinational from the offset. The status byte merges the pending flag with fixed identity bits. A write of any value to the status byte acknowledges the interrupt. The interrupt output is a level that follows the pending flag.

Top module: `fbc_ctrl_regs`

## Requirements
- R1: After reset every storage byte and the control byte read 0x00, the status byte reads 0x61 and irq_o is low.
- R2: The control byte at offset 0x10 reads back exactly the last value written to it.
- R3: A frame-end strobe sampled at a clock edge while control bit 7 is 1 sets the pending flag, and irq_o is high from that edge on. irq_o is not combinational from the strobe.
- R4: A frame-end strobe while control bit 7 is 0 leaves the pending flag clear and irq_o low.
- R5: A read of offset 0x11 returns the pending flag in bit 7 ORed with the constant 0x61 (bits 6:5 monitor code 3, bit 0 color board).
- R6: A write of any value to offset 0x11 clears the pending flag and lowers irq_o. The same write while nothing is pending changes no register and leaves irq_o low.
- R7: Offsets 0x12 to 0x1F are independent byte registers that read back their last written value. Offset 0x12 is cursor start, 0x13 is cursor end and 0x14 is video control.
- R8: When a frame-end strobe with enable set and a status write fall in the same cycle, the pending flag ends set.
- R9: Offsets 0x00 to 0x0F read as 0x00, and writes to them change no register.
- R10: The pending flag is sticky. Clearing control bit 7 or further strobes do not clear it; only a status write does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| addr_i | input | 5 | Byte offset within the 32-byte window |
| wr_en_i | input | 1 | Write strobe, one cycle per byte write |
| wr_data_i | input | 8 | Write data |
| frame_end_i | input | 1 | One-cycle frame-end pulse from the display side |
| rd_data_o | output | 8 | Combinational read data for addr_i |
| irq_o | output | 1 | Level interrupt, high while pending |

## Verification
The main function is tried with several strobe patterns:
- A strobe with the enable bit clear against one with it set. This separates the gating from the set itself.
- A status write alone against a status write in the same cycle as a strobe. This exposes the set-over-clear priority.
- A strobe after the enable bit has been cleared. This tells a sticky flag from one that tracks the enable.

Storage bytes are written with distinct values, including the bytes at both ends of the range, to show that their addresses stay apart. A write into the lower half of the window is followed by reads of the control and storage bytes, to show that the write reached nothing.

// File: rtl/fbc_pkg.sv
package fbc_pkg;
  localparam int unsigned FBC_ADDR_W   = 5;
  localparam int unsigned FBC_DATA_W   = 8;
  localparam int unsigned FBC_NUM_REGS = 16;
  localparam int unsigned FBC_CTRL_IDX = 0;
  localparam int unsigned FBC_STAT_IDX = 1;
  localparam int unsigned FBC_IE_BIT   = 7;
  localparam int unsigned FBC_PEND_BIT = 7;
  localparam logic [7:0]  FBC_ID_BITS  = 8'h61;
endpackage

// File: rtl/fbc_addr_dec.sv
module fbc_addr_dec #(
  parameter int unsigned ADDR_W   = 5,
  parameter int unsigned NUM_REGS = 16,
  parameter int unsigned STAT_IDX = 1,
  localparam int unsigned IDX_W   = $clog2(NUM_REGS)
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic              hit_o,
  output logic              stat_o,
  output logic [IDX_W-1:0]  idx_o
);
  // window occupies [NUM_REGS, 2*NUM_REGS)
  assign hit_o  = (addr_i[ADDR_W-1:IDX_W] == (ADDR_W-IDX_W)'(1));
  assign idx_o  = addr_i[IDX_W-1:0];
  assign stat_o = hit_o && (idx_o == IDX_W'(STAT_IDX));
endmodule

// File: rtl/fbc_byte_regs.sv
module fbc_byte_regs #(
  parameter int unsigned DATA_W   = 8,
  parameter int unsigned NUM_REGS = 16,
  parameter int unsigned STAT_IDX = 1,
  localparam int unsigned IDX_W   = $clog2(NUM_REGS)
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic                             we_i,
  input  logic [IDX_W-1:0]                 idx_i,
  input  logic [DATA_W-1:0]                data_i,
  output logic [NUM_REGS-1:0][DATA_W-1:0]  q_o
);
  for (genvar gi = 0; gi < NUM_REGS; gi++) begin : g_byte
    if (gi == STAT_IDX) begin : g_hole
      assign q_o[gi] = '0;  // status lives in irq logic
    end else begin : g_reg
      logic [DATA_W-1:0] q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                             q <= '0;
        else if (we_i && idx_i == IDX_W'(gi))    q <= data_i;
      end
      assign q_o[gi] = q;
    end
  end
endmodule

// File: rtl/fbc_irq_ctrl.sv
module fbc_irq_ctrl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic frame_end_i,
  input  logic enable_i,
  input  logic ack_i,
  output logic pending_o
);
  logic pend_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                       pend_q <= 1'b0;
    else if (frame_end_i && enable_i)  pend_q <= 1'b1;  // set wins over ack
    else if (ack_i)                    pend_q <= 1'b0;
  end
  assign pending_o = pend_q;
endmodule

// File: rtl/fbc_ctrl_regs.sv
module fbc_ctrl_regs
  import fbc_pkg::*;
#(
  parameter int unsigned ADDR_W   = FBC_ADDR_W,
  parameter int unsigned DATA_W   = FBC_DATA_W,
  parameter int unsigned NUM_REGS = FBC_NUM_REGS,
  parameter logic [DATA_W-1:0] ID_BITS = DATA_W'(FBC_ID_BITS),
  localparam int unsigned IDX_W   = $clog2(NUM_REGS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              frame_end_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              irq_o
);
  logic                            hit, stat_sel;
  logic [IDX_W-1:0]                idx;
  logic [NUM_REGS-1:0][DATA_W-1:0] regs;
  logic                            pending;
  logic                            irq_en;
  logic [DATA_W-1:0]               stat_val;

  fbc_addr_dec #(.ADDR_W(ADDR_W), .NUM_REGS(NUM_REGS), .STAT_IDX(FBC_STAT_IDX)) u_dec (
    .addr_i (addr_i),
    .hit_o  (hit),
    .stat_o (stat_sel),
    .idx_o  (idx)
  );

  fbc_byte_regs #(.DATA_W(DATA_W), .NUM_REGS(NUM_REGS), .STAT_IDX(FBC_STAT_IDX)) u_regs (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (wr_en_i && hit),
    .idx_i  (idx),
    .data_i (wr_data_i),
    .q_o    (regs)
  );

  assign irq_en = regs[FBC_CTRL_IDX][FBC_IE_BIT];

  fbc_irq_ctrl u_irq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .frame_end_i (frame_end_i),
    .enable_i    (irq_en),
    .ack_i       (wr_en_i && stat_sel),
    .pending_o   (pending)
  );

  always_comb begin
    stat_val = ID_BITS;
    stat_val[FBC_PEND_BIT] = pending;
  end

  always_comb begin
    if (!hit)          rd_data_o = '0;
    else if (stat_sel) rd_data_o = stat_val;
    else               rd_data_o = regs[idx];
  end

  assign irq_o = pending;
endmodule

// File: rtl/fbc_ctrl_regs_chk.sv
module fbc_ctrl_regs_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic [4:0] addr_i,
  input logic       wr_en_i,
  input logic       frame_end_i,
  input logic [7:0] rd_data_o,
  input logic       irq_o,
  input logic       irq_en
);
  logic stat_wr;
  assign stat_wr = wr_en_i && (addr_i == 5'h11);

  always @(posedge clk_i)
    if (!rst_ni) assert_reset_low_R1: assert (!irq_o);

  assert_set_on_strobe_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frame_end_i && irq_en) |=> irq_o);

  assert_rise_needs_enable_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> $past(frame_end_i && irq_en));

  assert_status_view_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == 5'h11) |-> (rd_data_o == {irq_o, 7'h61}));

  assert_ack_clears_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat_wr && !(frame_end_i && irq_en)) |=> !irq_o);

  assert_set_wins_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat_wr && frame_end_i && irq_en) |=> irq_o);

  assert_low_half_zero_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i < 5'h10) |-> (rd_data_o == 8'h00));

  assert_sticky_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && !stat_wr) |=> irq_o);
endmodule

bind fbc_ctrl_regs fbc_ctrl_regs_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .addr_i      (addr_i),
  .wr_en_i     (wr_en_i),
  .frame_end_i (frame_end_i),
  .rd_data_o   (rd_data_o),
  .irq_o       (irq_o),
  .irq_en      (irq_en)
);

// File: tb/fbc_ctrl_regs_bench.sv
module fbc_ctrl_regs_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [4:0] addr = '0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic       frame_end = 1'b0;
  logic [7:0] rd_data;
  logic       irq;
  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  fbc_ctrl_regs u_fbc_ctrl_regs (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wr_en_i(wr_en),
    .wr_data_i(wr_data), .frame_end_i(frame_end), .rd_data_o(rd_data), .irq_o(irq)
  );

  // {req[3:0], op[1:0], addr[4:0], data[7:0], exp[7:0]}; op 0=write 1=read 2=strobe
  localparam int NV = 24;
  localparam logic [26:0] VEC [NV] = '{
    {4'd2, 2'd0, 5'h10, 8'h80, 8'h00}, {4'd2, 2'd1, 5'h10, 8'h00, 8'h80},
    {4'd2, 2'd0, 5'h10, 8'h5A, 8'h00}, {4'd2, 2'd1, 5'h10, 8'h00, 8'h5A},
    {4'd7, 2'd0, 5'h12, 8'h11, 8'h00}, {4'd7, 2'd0, 5'h13, 8'h22, 8'h00},
    {4'd7, 2'd0, 5'h14, 8'h33, 8'h00}, {4'd7, 2'd0, 5'h1F, 8'hF0, 8'h00},
    {4'd7, 2'd1, 5'h12, 8'h00, 8'h11}, {4'd7, 2'd1, 5'h13, 8'h00, 8'h22},
    {4'd7, 2'd1, 5'h14, 8'h00, 8'h33}, {4'd7, 2'd1, 5'h1F, 8'h00, 8'hF0},
    {4'd9, 2'd0, 5'h02, 8'hAA, 8'h00}, {4'd9, 2'd1, 5'h02, 8'h00, 8'h00},
    {4'd9, 2'd1, 5'h10, 8'h00, 8'h5A}, {4'd9, 2'd1, 5'h12, 8'h00, 8'h11},
    {4'd5, 2'd1, 5'h11, 8'h00, 8'h61},
    {4'd4, 2'd2, 5'h00, 8'h00, 8'h00}, {4'd4, 2'd1, 5'h11, 8'h00, 8'h61},
    {4'd3, 2'd0, 5'h10, 8'h80, 8'h00}, {4'd3, 2'd2, 5'h00, 8'h00, 8'h00},
    {4'd3, 2'd1, 5'h11, 8'h00, 8'hE1},
    {4'd6, 2'd0, 5'h11, 8'h00, 8'h00}, {4'd6, 2'd1, 5'h11, 8'h00, 8'h61}
  };

  function automatic string req_name(input int r);
    case (r)
      1: return "R1"; 2: return "R2"; 3: return "R3"; 4: return "R4"; 5: return "R5";
      6: return "R6"; 7: return "R7"; 8: return "R8"; 9: return "R9"; default: return "R10";
    endcase
  endfunction

  task automatic do_write(input logic [4:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wr_data = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic strobe();
    @(negedge clk); frame_end = 1'b1;
    @(negedge clk); frame_end = 1'b0;
  endtask

  task automatic check_rd(input logic [4:0] a, input logic [7:0] exp, input string tag);
    addr = a; #1;
    total++;
    if (rd_data !== exp) begin
      bad++;
      $display("FAIL %s addr=%h actual=%h expected=%h", tag, a, rd_data, exp);
    end
  endtask

  task automatic check_irq(input logic exp, input string tag);
    #1; total++;
    if (irq !== exp) begin
      bad++;
      $display("FAIL %s irq actual=%b expected=%b", tag, irq, exp);
    end
  endtask

  task automatic check_reset_state(input string tag);
    check_irq(1'b0, tag);
    check_rd(5'h10, 8'h00, tag);
    check_rd(5'h11, 8'h61, tag);
    for (int i = 5'h12; i <= 5'h1F; i++) check_rd(5'(i), 8'h00, tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check_reset_state("R1");

    for (int v = 0; v < NV; v++) begin
      case (VEC[v][22:21])
        2'd0: do_write(VEC[v][20:16], VEC[v][15:8]);
        2'd2: strobe();
        default: begin
          @(negedge clk);
          check_rd(VEC[v][20:16], VEC[v][7:0], req_name(int'(VEC[v][26:23])));
        end
      endcase
    end

    // R3: registered set, not combinational
    @(negedge clk); frame_end = 1'b1;
    check_irq(1'b0, "R3");
    @(negedge clk); frame_end = 1'b0;
    check_irq(1'b1, "R3");

    // R10: sticky across enable clear and further strobes
    do_write(5'h10, 8'h00);
    check_irq(1'b1, "R10");
    strobe();
    check_irq(1'b1, "R10");
    check_rd(5'h11, 8'hE1, "R10");
    do_write(5'h11, 8'hFF);
    check_irq(1'b0, "R6");

    // R6: ack with nothing pending changes nothing
    do_write(5'h10, 8'h80);
    do_write(5'h11, 8'h3C);
    check_irq(1'b0, "R6");
    check_rd(5'h11, 8'h61, "R6");
    check_rd(5'h10, 8'h80, "R6");
    check_rd(5'h13, 8'h22, "R6");

    // R8: strobe and ack in the same cycle
    @(negedge clk); frame_end = 1'b1; addr = 5'h11; wr_data = 8'h00; wr_en = 1'b1;
    @(negedge clk); frame_end = 1'b0; wr_en = 1'b0;
    check_irq(1'b1, "R8");
    check_rd(5'h11, 8'hE1, "R8");

    // R9: write to low half leaves pending and control alone
    do_write(5'h01, 8'h00);
    check_irq(1'b1, "R9");
    check_rd(5'h10, 8'h80, "R9");

    // R1: mid-run reset clears everything
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    check_reset_state("R1");

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule